// File: doc/BRIEF.md
# Bit-Serial Integer Datapath

This block is the execute path of a very small 32-bit integer processor built for minimum area instead of speed. Every architectural register is a shift register that rotates through its own output. A single-bit ALU consumes one bit of each source operand per clock and returns one result bit per clock. An operation therefore takes one clock per data bit. There is no wide adder, no wide multiplexer and no second register-file port.

A controller issues an operation by giving a code, two source register numbers and a destination register number, then pulsing `start_i` for one clock. All registers rotate during the next 32 clocks. The destination takes the ALU bits in place of its own recirculated bits. A one-clock `done_o` pulse then reports that the result is complete. A serial input lets external data, such as a memory load, be shifted into a register. A serial tap shows the low bit of any register, so a value can be read out while the registers rotate.

Top module: `serial_int_core`

## Requirements
- R1: Operation code 0 writes `rs1 + rs2` modulo 2^32 into `rd`. Bits are processed least significant first.
- R2: Code 1 writes `rs1 - rs2` modulo 2^32. It is formed as rs1 plus the inverted rs2, with a carry-in of 1.
- R3: Codes 2, 3 and 4 write the bitwise AND, OR and XOR of the two sources.
- R4: Code 5 compares the sources as signed numbers. It writes 1 into `rd` when rs1 is less than rs2, and 0 otherwise. Bits 31 to 1 of `rd` are always zero afterwards.
- R5: Code 6 shifts `ser_i` into `rd`. The value sampled at the k-th clock edge after the start edge becomes bit k-1. Code 7 copies `rs1` into `rd`.
- R6: Every register other than the destination holds its value across an operation.
- R7: Register 0 always reads as zero, and writes to it are dropped.
- R8: When `rd` equals a source, that source supplies its value from before the operation.
- R9: `start_i` is accepted on a clock edge while the block is idle. `done_o` then rises after the 32nd following edge and stays high for exactly one clock. A new start may be accepted on that edge.
- R10: `start_i` and changes on the operand inputs while an operation is running are ignored.
- R11: After reset every register reads zero and `done_o` is low.
- R12: `tap_o` shows the low bit of the register selected by `tap_sel_i`. During the k-th clock of an operation (k from 0), this is bit k of that register's value before the operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (idle only) |
| op_i | input | 3 | Operation code |
| rs1_i | input | 5 | First source register |
| rs2_i | input | 5 | Second source register |
| rd_i | input | 5 | Destination register |
| ser_i | input | 1 | Serial data for code 6 |
| tap_sel_i | input | 5 | Register shown on tap_o |
| tap_o | output | 1 | Low bit of the selected register |
| done_o | output | 1 | One-clock completion pulse |

## Verification
The hardest situation to reach from the ports is a destination that is also a source. The old value must leave the low end one bit before the new bit enters the high end. The bench runs an add and then a subtract with all three register numbers the same. Each source must then show its value from before the operation, which gives a doubled value and then zero.

A second hard case is a start arriving mid-operation. The bench raises `start_i` together with a different code and destination in the middle of an add. It then checks three things: the add result is intact, the would-be destination is untouched, and no second done pulse follows.

// File: rtl/sbit_pkg.sv
package sbit_pkg;
  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_AND  = 3'd2,
    OP_OR   = 3'd3,
    OP_XOR  = 3'd4,
    OP_SLT  = 3'd5,
    OP_LOAD = 3'd6,
    OP_MOVE = 3'd7
  } alu_op_e;
endpackage

// File: rtl/sbit_seq.sv
module sbit_seq #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned CW = $clog2(WIDTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          accept_o,
  output logic          busy_o,
  output logic [CW-1:0] cnt_o,
  output logic          first_o,
  output logic          last_o,
  output logic          done_o
);
  localparam logic [CW-1:0] CNT_MAX = CW'(WIDTH - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign accept_o = start_i && !busy_q;
  assign first_o  = busy_q && (cnt_q == '0);
  assign last_o   = busy_q && (cnt_q == CNT_MAX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= last_o;
      if (accept_o) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (cnt_q == CNT_MAX) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;
  assign done_o = done_q;
endmodule

// File: rtl/sbit_alu.sv
module sbit_alu
  import sbit_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    en_i,
  input  logic    first_i,
  input  alu_op_e op_i,
  input  logic    a_i,
  input  logic    b_i,
  input  logic    ser_i,
  output logic    res_o,
  output logic    lt_o
);
  logic carry_q;
  logic inv_b, b_eff, cin, sum, cout;

  assign inv_b = (op_i == OP_SUB) || (op_i == OP_SLT);
  assign b_eff = b_i ^ inv_b;
  // carry seeded on bit 0: 0 for add, 1 for subtract/compare
  assign cin   = first_i ? inv_b : carry_q;
  assign sum   = a_i ^ b_eff ^ cin;
  assign cout  = (a_i & b_eff) | (cin & (a_i ^ b_eff));
  // sign of difference corrected by overflow; valid on the top bit
  assign lt_o  = sum ^ (cin ^ cout);

  always_comb begin
    unique case (op_i)
      OP_ADD, OP_SUB: res_o = sum;
      OP_AND:         res_o = a_i & b_i;
      OP_OR:          res_o = a_i | b_i;
      OP_XOR:         res_o = a_i ^ b_i;
      OP_SLT:         res_o = 1'b0;
      OP_LOAD:        res_o = ser_i;
      OP_MOVE:        res_o = a_i;
      default:        res_o = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   carry_q <= 1'b0;
    else if (en_i) carry_q <= cout;
  end
endmodule

// File: rtl/sbit_regfile.sv
module sbit_regfile #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned NREGS = 32,
  localparam int unsigned AW = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          shift_i,
  input  logic [AW-1:0] rs1_i,
  input  logic [AW-1:0] rs2_i,
  input  logic [AW-1:0] rd_i,
  input  logic [AW-1:0] tap_sel_i,
  input  logic          wbit_i,
  input  logic          flag_wr_i,
  input  logic          flag_i,
  output logic          a_o,
  output logic          b_o,
  output logic          tap_o
);
  logic [NREGS-1:0] lsb;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign lsb[g] = 1'b0;
    end else begin : g_store
      logic [WIDTH-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          q <= '0;
        end else if (shift_i) begin
          if (rd_i == AW'(g)) begin
            // last compare bit replaces the whole word
            if (flag_wr_i) q <= {{(WIDTH-1){1'b0}}, flag_i};
            else           q <= {wbit_i, q[WIDTH-1:1]};
          end else begin
            q <= {q[0], q[WIDTH-1:1]};
          end
        end
      end
      assign lsb[g] = q[0];
    end
  end

  assign a_o   = lsb[rs1_i];
  assign b_o   = lsb[rs2_i];
  assign tap_o = lsb[tap_sel_i];
endmodule

// File: rtl/serial_int_core.sv
module serial_int_core
  import sbit_pkg::*;
#(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned NREGS = 32,
  localparam int unsigned AW = $clog2(NREGS),
  localparam int unsigned CW = $clog2(WIDTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    op_i,
  input  logic [AW-1:0] rs1_i,
  input  logic [AW-1:0] rs2_i,
  input  logic [AW-1:0] rd_i,
  input  logic          ser_i,
  input  logic [AW-1:0] tap_sel_i,
  output logic          tap_o,
  output logic          done_o
);
  logic          accept, busy, first, last;
  logic [CW-1:0] cnt;
  alu_op_e       op_q;
  logic [AW-1:0] rs1_q, rs2_q, rd_q;
  logic          a_bit, b_bit, r_bit, lt_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= OP_ADD;
      rs1_q <= '0;
      rs2_q <= '0;
      rd_q  <= '0;
    end else if (accept) begin
      op_q  <= alu_op_e'(op_i);
      rs1_q <= rs1_i;
      rs2_q <= rs2_i;
      rd_q  <= rd_i;
    end
  end

  sbit_seq #(.WIDTH(WIDTH)) i_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .accept_o (accept),
    .busy_o   (busy),
    .cnt_o    (cnt),
    .first_o  (first),
    .last_o   (last),
    .done_o   (done_o)
  );

  sbit_alu i_alu (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (busy),
    .first_i (first),
    .op_i    (op_q),
    .a_i     (a_bit),
    .b_i     (b_bit),
    .ser_i   (ser_i),
    .res_o   (r_bit),
    .lt_o    (lt_bit)
  );

  sbit_regfile #(.WIDTH(WIDTH), .NREGS(NREGS)) i_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_i   (busy),
    .rs1_i     (rs1_q),
    .rs2_i     (rs2_q),
    .rd_i      (rd_q),
    .tap_sel_i (tap_sel_i),
    .wbit_i    (r_bit),
    .flag_wr_i (last && (op_q == OP_SLT)),
    .flag_i    (lt_bit),
    .a_o       (a_bit),
    .b_o       (b_bit),
    .tap_o     (tap_o)
  );
endmodule

// File: rtl/serial_int_core_chk.sv
module serial_int_core_chk #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned NREGS = 32,
  localparam int unsigned AW = $clog2(NREGS),
  localparam int unsigned CW = $clog2(WIDTH)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          done_o,
  input logic          tap_o,
  input logic [AW-1:0] tap_sel_i,
  input logic          busy,
  input logic [CW-1:0] cnt,
  input logic [2:0]    op_q
);
  localparam logic [CW-1:0] CNT_MAX = CW'(WIDTH - 1);

  AST_DONE_ONE_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cnt == CNT_MAX) |=> (done_o && !busy)); // R9
  AST_IDLE_START_TAKEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && start_i) |=> (busy && cnt == '0)); // R9
  AST_BUSY_ADVANCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cnt != CNT_MAX) |=> (busy && cnt == CW'($past(cnt) + 1'b1))); // R10
  AST_OP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && cnt != CNT_MAX) |=> $stable(op_q)); // R10
  AST_ZERO_REG_TAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tap_sel_i == '0) |-> !tap_o); // R7
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy); // R9
endmodule

bind serial_int_core serial_int_core_chk #(.WIDTH(WIDTH), .NREGS(NREGS)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .done_o    (done_o),
  .tap_o     (tap_o),
  .tap_sel_i (tap_sel_i),
  .busy      (busy),
  .cnt       (cnt),
  .op_q      (op_q)
);

// File: tb/test_serial_int_core.sv
module test_serial_int_core;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;
  localparam int NVEC = 13;

  // {op, a, b, expected}
  localparam logic [98:0] VEC [NVEC] = '{
    {3'd0, 32'h12345678, 32'h0FEDCBA9, 32'h22222221},
    {3'd0, 32'hFFFFFFFF, 32'h00000001, 32'h00000000},
    {3'd1, 32'h00000005, 32'h00000007, 32'hFFFFFFFE},
    {3'd1, 32'h80000000, 32'h00000001, 32'h7FFFFFFF},
    {3'd2, 32'hF0F0A5A5, 32'h0FF0FF00, 32'h00F0A500},
    {3'd3, 32'hF0F0A5A5, 32'h0FF0FF00, 32'hFFF0FFA5},
    {3'd4, 32'hF0F0A5A5, 32'h0FF0FF00, 32'hFF005AA5},
    {3'd5, 32'h80000000, 32'h00000001, 32'h00000001},
    {3'd5, 32'h00000005, 32'h00000003, 32'h00000000},
    {3'd5, 32'h7FFFFFFF, 32'h80000000, 32'h00000000},
    {3'd5, 32'hFFFFFFFF, 32'h00000000, 32'h00000001},
    {3'd5, 32'h00000003, 32'h00000003, 32'h00000000},
    {3'd7, 32'hDEADBEEF, 32'h00000000, 32'hDEADBEEF}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [2:0] op_i = '0;
  logic [4:0] rs1_i = '0, rs2_i = '0, rd_i = '0, tap_sel_i = '0;
  logic       ser_i = 1'b0;
  logic       tap_o, done_o;

  int n_checks = 0;
  int n_fail = 0;
  logic done_end, done_next;

  always #(HALF) clk_i = ~clk_i;

  serial_int_core i_serial_int_core (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .rs1_i(rs1_i), .rs2_i(rs2_i), .rd_i(rd_i), .ser_i(ser_i),
    .tap_sel_i(tap_sel_i), .tap_o(tap_o), .done_o(done_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; poke_k >= 0 raises a stray start in that cycle
  task automatic do_op(input logic [2:0] op, input int s1, input int s2, input int d,
                       input int ts, input logic [31:0] sw, input int poke_k,
                       output logic [31:0] tw);
    op_i = op; rs1_i = 5'(s1); rs2_i = 5'(s2); rd_i = 5'(d); tap_sel_i = 5'(ts);
    start_i = 1'b1;
    @(posedge clk_i); #(HALF);
    start_i = 1'b0;
    for (int k = 0; k < 32; k++) begin
      ser_i = sw[k];
      tw[k] = tap_o;
      if (k == poke_k) begin
        start_i = 1'b1; op_i = 3'd2; rd_i = 5'd9; rs1_i = 5'd0;
      end else if (k == poke_k + 1) begin
        start_i = 1'b0;
      end
      @(posedge clk_i); #(HALF);
    end
    done_end = done_o;
    @(posedge clk_i); #(HALF);
    done_next = done_o;
  endtask

  task automatic load(input int d, input logic [31:0] v);
    logic [31:0] t;
    do_op(3'd6, 0, 0, d, 0, v, -1, t);
  endtask

  task automatic read(input int r, output logic [31:0] v);
    do_op(3'd7, r, 0, 0, r, 32'h0, -1, v);
  endtask

  function automatic string op_tag(input logic [2:0] op);
    case (op)
      3'd0: return "R1 add";
      3'd1: return "R2 sub";
      3'd2, 3'd3, 3'd4: return "R3 logic";
      3'd5: return "R4 slt";
      default: return "R5 move";
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, t;
    #(CLK_PERIOD * 2 + 1);
    check("R11 done after reset", 32'(done_o), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    read(1, v);  check("R11 r1 reset", v, 32'h0);
    read(31, v); check("R11 r31 reset", v, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      logic [98:0] e;
      e = VEC[i];
      load(1, e[95:64]);
      load(2, e[63:32]);
      do_op(e[98:96], 1, 2, 3, 1, 32'h0, -1, t);
      check("R12 tap during op", t, e[95:64]);
      check("R9 done pulse", {30'h0, done_end, done_next}, 32'h2);
      read(3, v); check(op_tag(e[98:96]), v, e[31:0]);
      read(1, v); check("R6 rs1 kept", v, e[95:64]);
      read(2, v); check("R6 rs2 kept", v, e[63:32]);
    end

    load(5, 32'hCAFEF00D);
    load(0, 32'hFFFFFFFF);
    read(0, v); check("R7 r0 write dropped", v, 32'h0);
    do_op(3'd0, 0, 5, 6, 0, 32'h0, -1, t);
    read(6, v); check("R7 r0 reads zero", v, 32'hCAFEF00D);
    read(5, v); check("R5 load value", v, 32'hCAFEF00D);

    load(4, 32'd10);
    do_op(3'd0, 4, 4, 4, 0, 32'h0, -1, t);
    read(4, v); check("R8 add alias", v, 32'd20);
    do_op(3'd1, 4, 4, 4, 0, 32'h0, -1, t);
    read(4, v); check("R8 sub alias", v, 32'd0);
    load(4, 32'hFFFFFFFE);
    do_op(3'd5, 4, 4, 4, 0, 32'h0, -1, t);
    read(4, v); check("R8 slt alias", v, 32'd0);

    load(6, 32'd100);
    load(7, 32'd3);
    load(9, 32'h0);
    do_op(3'd0, 6, 7, 8, 0, 32'h0, 5, t);
    check("R10 single done", {30'h0, done_end, done_next}, 32'h2);
    read(8, v); check("R10 result intact", v, 32'd103);
    read(9, v); check("R10 stray dest untouched", v, 32'h0);
    for (int k = 0; k < 40; k++) begin
      if (done_o) begin
        check("R10 no extra done", 32'h1, 32'h0);
        break;
      end
      @(negedge clk_i);
    end
    read(6, v); check("R6 r6 kept", v, 32'd100);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule